// File: doc/BRIEF.md
# Global Memory Access Coalescer

This block takes the load or store requests of a sixteen-lane thread group and turns them into as few aligned memory transactions as it can. Each lane gives a byte address, an element size and an active flag. A one-cycle `start` pulse captures the whole group. The block then works through it in rounds, issuing one transaction per round on a valid/ready stream. Each transaction carries a base address, a size code and the mask of the lanes it serves.

In every round, the lowest-numbered lane that is still pending becomes the leader. The leader's element width sets the segment size. The block finds the aligned segment that holds the leader's address, and every other pending lane whose address falls in that segment joins the round. The block then looks at which 32-byte quarters the joined lanes actually touch and shrinks the transaction where it can. When the transaction is accepted, the lanes it served are retired. A one-cycle `done` pulse follows the last acceptance.

Addresses are assumed to be naturally aligned to their element size, so an element never crosses a 32-byte boundary.

Top module: `gmem_coalescer`

## Requirements
- R1: Segment size follows the leader's element-size code. `thr_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Code 0 gives a 32-byte segment, code 1 gives 64 bytes, and codes 2 and 3 give 128 bytes. `txn_size` is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes; the value 3 never appears.
- R2: Each round is led by the lowest-numbered pending lane. `txn_base` is aligned to the transaction size and lies within the leader's aligned segment.
- R3: `txn_mask` (bit i for lane i) holds every pending lane whose address lies in the leader's segment, and no other lane.
- R4: A 128-byte transaction whose lanes touch only one aligned 64-byte half is issued as 64 bytes at that half.
- R5: A 64-byte transaction, whether original or reduced under R4, whose lanes touch only one aligned 32-byte quarter is issued as 32 bytes at that quarter.
- R6: An accepted transaction retires its lanes. Rounds continue until no lane is pending. `done` pulses high for one cycle, on the cycle after the last acceptance, with `txn_valid` low.
- R7: Lanes whose `thr_active` bit was low at `start` never appear in any mask.
- R8: While `txn_valid` is high and `txn_ready` is low, the base, size and mask hold steady, and no later round begins.
- R9: A group with no active lane issues no transaction, and `done` pulses on the cycle after `start`.
- R10: A `start` pulse arriving while `busy` is high is ignored. The group already in progress is unaffected.
- R11: After reset, `txn_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures the group when idle |
| thr_active | input | N_THR | Per-lane active flags |
| thr_addr | input | N_THR*ADDR_W | Per-lane byte addresses; lane i is at [i*ADDR_W +: ADDR_W] |
| thr_size | input | 2*N_THR | Per-lane element-size codes; lane i is at [2i +: 2] |
| busy | output | 1 | High while a group is being served |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The consumer accepts the offered transaction |
| txn_base | output | ADDR_W | Aligned base address of the transaction |
| txn_size | output | 2 | Transaction size code |
| txn_mask | output | N_THR | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse when the group is finished |

## Verification
The bench uses the default parameters: sixteen lanes and 32-bit addresses. With these values the full mask is visible, and the bench can exercise all three segment sizes and both shrink steps, including a 128-byte segment reduced all the way to 32 bytes.

Its stride patterns are chosen to cover several cases. One pattern splits a group across neighbouring segments. Another uses a sparse active mask, which leaves gaps between the lanes. A descending-address pattern makes a later round's leader sit at a lower address than an earlier one.

Directed cases cover the remaining behaviour: held-off acceptance, a start pulse sent while the block is busy, and an empty group.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic {ST_IDLE, ST_ISSUE} coal_state_e;

    localparam logic [1:0] SZ_32  = 2'd0;
    localparam logic [1:0] SZ_64  = 2'd1;
    localparam logic [1:0] SZ_128 = 2'd2;

    function automatic logic [1:0] seg_code_of(input logic [1:0] elem_code);
        case (elem_code)
            2'd0:    return SZ_32;
            2'd1:    return SZ_64;
            default: return SZ_128;
        endcase
    endfunction
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
    parameter int N_THR = 16,
    localparam int IDX_W = $clog2(N_THR)
) (
    input  logic [N_THR-1:0] pending,
    output logic [IDX_W-1:0] lead_idx
);
    always_comb begin
        lead_idx = '0;
        for (int i = N_THR - 1; i >= 0; i--) begin
            if (pending[i]) lead_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coal_segment.sv
module coal_segment #(
    parameter int N_THR  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [N_THR-1:0]        pending,
    input  logic [N_THR*ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]       lead_addr,
    input  logic [1:0]              seg_code,
    output logic [N_THR-1:0]        hit_mask,
    output logic [3:0]              quarters
);
    logic [ADDR_W-1:0] seg_keep;
    logic [3:0]        q_hot [N_THR];

    assign seg_keep = ~((ADDR_W'(32) << seg_code) - ADDR_W'(1));

    for (genvar g = 0; g < N_THR; g++) begin : g_lane
        logic [ADDR_W-1:0] a;
        assign a           = addrs[g*ADDR_W +: ADDR_W];
        assign hit_mask[g] = pending[g] && ((a & seg_keep) == (lead_addr & seg_keep));
        assign q_hot[g]    = hit_mask[g] ? (4'b0001 << a[6:5]) : 4'b0000;
    end

    always_comb begin
        quarters = 4'b0000;
        for (int i = 0; i < N_THR; i++) quarters = quarters | q_hot[i];
    end
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [1:0]        seg_code,
    input  logic [3:0]        quarters,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        size
);
    import coal_pkg::*;

    logic       half;
    logic [1:0] quad;
    logic [1:0] in_half;

    always_comb begin
        size = seg_code;
        half = lead_addr[6];
        quad = lead_addr[6:5];
        if (seg_code == SZ_128) begin
            if (quarters[3:2] == 2'b00) begin
                size = SZ_64;
                half = 1'b0;
            end else if (quarters[1:0] == 2'b00) begin
                size = SZ_64;
                half = 1'b1;
            end
        end
        in_half = half ? quarters[3:2] : quarters[1:0];
        if (size == SZ_64) begin
            if (in_half == 2'b01) begin
                size = SZ_32;
                quad = {half, 1'b0};
            end else if (in_half == 2'b10) begin
                size = SZ_32;
                quad = {half, 1'b1};
            end
        end
        base = lead_addr & ~ADDR_W'(127);
        if (size == SZ_64)      base[6]   = half;
        else if (size == SZ_32) base[6:5] = quad;
    end
endmodule

// File: rtl/gmem_coalescer.sv
module gmem_coalescer #(
    parameter int N_THR  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_THR-1:0]        thr_active,
    input  logic [N_THR*ADDR_W-1:0] thr_addr,
    input  logic [2*N_THR-1:0]      thr_size,
    output logic                    busy,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [1:0]              txn_size,
    output logic [N_THR-1:0]        txn_mask,
    output logic                    done
);
    import coal_pkg::*;

    localparam int IDX_W = $clog2(N_THR);

    typedef struct packed {
        coal_state_e             state;
        logic [N_THR-1:0]        pending;
        logic [N_THR*ADDR_W-1:0] addrs;
        logic [2*N_THR-1:0]      sizes;
        logic                    done;
    } coal_reg_t;

    coal_reg_t          st_d, st_q;
    logic [IDX_W-1:0]   lead_idx;
    logic [ADDR_W-1:0]  lead_addr;
    logic [1:0]         seg_code;
    logic [N_THR-1:0]   hit_mask;
    logic [3:0]         quarters;
    logic [N_THR-1:0]   left_over;

    coal_leader #(.N_THR(N_THR)) u_leader (
        .pending  (st_q.pending),
        .lead_idx (lead_idx)
    );

    assign lead_addr = st_q.addrs[lead_idx*ADDR_W +: ADDR_W];
    assign seg_code  = seg_code_of(st_q.sizes[lead_idx*2 +: 2]);

    coal_segment #(.N_THR(N_THR), .ADDR_W(ADDR_W)) u_segment (
        .pending   (st_q.pending),
        .addrs     (st_q.addrs),
        .lead_addr (lead_addr),
        .seg_code  (seg_code),
        .hit_mask  (hit_mask),
        .quarters  (quarters)
    );

    coal_shrink #(.ADDR_W(ADDR_W)) u_shrink (
        .lead_addr (lead_addr),
        .seg_code  (seg_code),
        .quarters  (quarters),
        .base      (txn_base),
        .size      (txn_size)
    );

    assign left_over = st_q.pending & ~hit_mask;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.addrs   = thr_addr;
                    st_d.sizes   = thr_size;
                    st_d.pending = thr_active;
                    if (thr_active == '0) st_d.done  = 1'b1;
                    else                  st_d.state = ST_ISSUE;
                end
            end
            default: begin
                if (txn_ready) begin
                    st_d.pending = left_over;
                    if (left_over == '0) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, pending: '0, addrs: '0, sizes: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign txn_valid = (st_q.state == ST_ISSUE);
    assign txn_mask  = hit_mask;
    assign busy      = (st_q.state != ST_IDLE);
    assign done      = st_q.done;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int N_THR  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_base,
    input logic [1:0]        txn_size,
    input logic [N_THR-1:0]  txn_mask,
    input logic [N_THR-1:0]  pending,
    input logic              done
);
    // R8: offer holds while backpressured
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base)
                                    && $stable(txn_size) && $stable(txn_mask));

    // R1: size code 3 never issued
    a_r1_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_size != 2'd3);

    // R2: base aligned to the transaction size
    a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_base[4:0] == 5'd0)
                      && (txn_size == 2'd0 || !txn_base[5])
                      && (txn_size != 2'd2 || !txn_base[6]));

    // R2: lowest pending lane leads the round
    a_r2_leader_first: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask & (~txn_mask + 1'b1)) == (pending & (~pending + 1'b1)));

    // R7: mask only names pending lanes, and at least one
    a_r7_mask_pending: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask & ~pending) == '0) && (txn_mask != '0));

    // R6: accepted lanes leave the pending set
    a_r6_retire: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready |=> pending == ($past(pending) & ~$past(txn_mask)));

    // R6: done never overlaps an offer
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !txn_valid);
endmodule

bind gmem_coalescer coal_checker #(.N_THR(N_THR), .ADDR_W(ADDR_W)) u_coal_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_size  (txn_size),
    .txn_mask  (txn_mask),
    .pending   (st_q.pending),
    .done      (done)
);

// File: tb/tb_gmem_coalescer.sv
`timescale 1ns/1ps
module tb_gmem_coalescer;
    localparam int N  = 16;
    localparam int AW = 32;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  thr_active = '0;
    logic [N*AW-1:0] thr_addr = '0;
    logic [2*N-1:0]  thr_size = '0;
    logic          busy, txn_valid, done;
    logic          txn_ready = 1'b1;
    logic [AW-1:0] txn_base;
    logic [1:0]    txn_size;
    logic [N-1:0]  txn_mask;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gmem_coalescer #(.N_THR(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .thr_active(thr_active),
        .thr_addr(thr_addr), .thr_size(thr_size), .busy(busy),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
        .txn_size(txn_size), .txn_mask(txn_mask), .done(done)
    );

    // vector: base, stride, size code, active, count, then expected transactions
    localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h5040,
                                           32'h6000, 32'h7000, 32'h8000, 32'h90F0, 32'h3400};
    localparam logic [31:0] V_STR  [NV] = '{32'd4, 32'd1, 32'd2, 32'd8, 32'd4,
                                           32'd16, 32'd128, 32'd32, 32'hFFFFFFC0, 32'd4};
    localparam logic [1:0]  V_SZ   [NV] = '{2'd2, 2'd0, 2'd1, 2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd1};
    localparam logic [15:0] V_ACT  [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
                                           16'hFFFF, 16'h000F, 16'hAAAA, 16'h0007, 16'hFFFF};
    localparam int          V_N    [NV] = '{1, 1, 1, 1, 1, 2, 4, 4, 2, 1};
    localparam logic [31:0] X_BASE [NV][4] = '{
        '{32'h1000, 0, 0, 0}, '{32'h2000, 0, 0, 0}, '{32'h3000, 0, 0, 0}, '{32'h4000, 0, 0, 0},
        '{32'h5040, 0, 0, 0}, '{32'h6000, 32'h6080, 0, 0},
        '{32'h7000, 32'h7080, 32'h7100, 32'h7180}, '{32'h8000, 32'h8080, 32'h8100, 32'h8180},
        '{32'h9080, 32'h9060, 0, 0}, '{32'h3400, 0, 0, 0}};
    localparam logic [1:0]  X_SZ   [NV][4] = '{
        '{1, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{2, 0, 0, 0}, '{1, 0, 0, 0},
        '{2, 2, 0, 0}, '{0, 0, 0, 0}, '{2, 2, 2, 2}, '{2, 0, 0, 0}, '{1, 0, 0, 0}};
    localparam logic [15:0] X_MASK [NV][4] = '{
        '{16'hFFFF, 0, 0, 0}, '{16'hFFFF, 0, 0, 0}, '{16'hFFFF, 0, 0, 0}, '{16'hFFFF, 0, 0, 0},
        '{16'hFFFF, 0, 0, 0}, '{16'h00FF, 16'hFF00, 0, 0},
        '{16'h0001, 16'h0002, 16'h0004, 16'h0008}, '{16'h000A, 16'h00A0, 16'h0A00, 16'hA000},
        '{16'h0003, 16'h0004, 0, 0}, '{16'hFFFF, 0, 0, 0}};

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_group(input logic [31:0] base, input logic [31:0] stride,
                              input logic [1:0] sz, input logic [15:0] act);
        for (int i = 0; i < N; i++) begin
            thr_addr[i*AW +: AW] = base + stride * i;
            thr_size[2*i +: 2]   = sz;
        end
        thr_active = act;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!txn_valid && !busy && !done, "R11 reset outputs", {29'd0, txn_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int k;
            logic seen_done;
            load_group(V_BASE[v], V_STR[v], V_SZ[v], V_ACT[v]);
            txn_ready = 1'b1;
            pulse_start();
            k = 0;
            seen_done = 1'b0;
            for (int c = 0; c < 40 && !seen_done; c++) begin
                if (txn_valid) begin
                    if (k < 4) begin
                        check(txn_base == X_BASE[v][k], "R2/R4/R5 base", txn_base, X_BASE[v][k]);
                        check(txn_size == X_SZ[v][k], "R1/R4/R5 size", {30'd0, txn_size}, {30'd0, X_SZ[v][k]});
                        check(txn_mask == X_MASK[v][k], "R3/R7 mask", {16'd0, txn_mask}, {16'd0, X_MASK[v][k]});
                    end
                    k++;
                end
                if (done) seen_done = 1'b1;
                else @(negedge clk);
            end
            check(seen_done && !txn_valid, "R6 done pulse", {31'd0, seen_done}, 1);
            check(k == V_N[v], "R6 round count", k, V_N[v]);
            @(negedge clk);
        end

        // R8 backpressure and R10 start ignored while busy
        load_group(32'h6000, 32'd16, 2'd2, 16'hFFFF);
        txn_ready = 1'b0;
        pulse_start();
        for (int c = 0; c < 3; c++) begin
            check(txn_valid && txn_base == 32'h6000 && txn_mask == 16'h00FF,
                  "R8 held offer", txn_base, 32'h6000);
            load_group(32'h1000, 32'd4, 2'd2, 16'hFFFF);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        check(busy, "R10 still busy", {31'd0, busy}, 1);
        txn_ready = 1'b1;
        check(txn_base == 32'h6000 && txn_mask == 16'h00FF, "R10 first txn kept", txn_base, 32'h6000);
        @(negedge clk);
        check(txn_valid && txn_base == 32'h6080 && txn_mask == 16'hFF00, "R10 second txn kept", txn_base, 32'h6080);
        @(negedge clk);
        check(done && !txn_valid && !busy, "R6 done after last", {31'd0, done}, 1);
        @(negedge clk);

        // R9: empty group
        load_group(32'h1000, 32'd4, 2'd2, 16'h0000);
        pulse_start();
        check(done && !txn_valid && !busy, "R9 empty group done", {31'd0, done}, 1);
        @(negedge clk);
        check(!done && !txn_valid, "R9 no transaction", {30'd0, done, txn_valid}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule